// File: doc/BRIEF.md
# Reversible Memory Cell Access Sequencer

This block sequences access to an array of reversible memory cells. Each cell node and each bit line carries one of three levels: low, mid or high. A write stores a row. A read copies a row into a column-end latch. Each of these has an exact inverse that runs the same steps in the opposite order: an un-write clears a stored row back to mid, and an un-read retracts the latched copy. Between operations every bit line sits at mid. As a result, a row transmission gate only ever opens when both of its sides are at the same level.

The host issues commands on a valid/ready channel carrying an operation code, a row address and row data. The controller moves forward one step for each tick strobe. It reports completion with a one-cycle done pulse. If it refuses the command, err is raised in the same cycle as done. A behavioural cell-array model is included in the block so that stored contents can be observed through reads. The outputs show the row gate enables, the per-column bit-line levels and the per-row inverter rail split.

Top module: `rcell_access_seq`

## Requirements
- R1: After reset, busy, done and err are 0. tg_en and rail_split are 0, every bit-line level is mid, rd_data is 0 and cmd_ready is 1. The level code is 2'b00 for low, 2'b01 for mid and 2'b10 for high. Column c uses bl_lvl[2c+1:2c].
- R2: A command is taken in a cycle where both cmd_valid and cmd_ready are 1. cmd_ready is 1 only while the block is idle with no gate open, no rail split and every bit line at mid. busy stays 1 from acceptance until done. A held cmd_valid is simply back-pressured.
- R3: While busy, outputs advance only on a clock edge where tick is 1. Without tick, they hold.
- R4: A write (cmd_op 2'b00) runs four ticks after acceptance. Tick 1 opens the row gate with bit lines at mid. Tick 2 drives each line high for a 1 bit and low for a 0 bit. Tick 3 closes the gate with the lines still driven. Tick 4 returns the lines to mid and pulses done.
- R5: A write to a row that has any cell not at mid is refused with err. Nothing is changed.
- R6: A read (cmd_op 2'b10) runs three ticks. Tick 1 splits the row's rails, and each bit line shows the inverted cell level. Tick 2 captures the lines into the column latch, so rd_data equals the stored row. Tick 3 merges the rails, and the lines return to mid with done.
- R7: A read while a column copy is held is refused with err.
- R8: An un-write (cmd_op 2'b01) presents the stored data on the lines with the gate closed, opens the gate, returns the lines to mid and closes the gate, one step per tick. The row is left at mid and can then be written again.
- R9: An un-write whose data differs from the stored row is refused with err. The row keeps its contents.
- R10: An un-read (cmd_op 2'b11) is accepted only for the row whose copy is held, and is refused with err otherwise. It splits the rails (the lines match the copy), clears the copy so that rd_data becomes 0, then merges the rails with done.
- R11: done is a one-cycle pulse. err is 1 only together with done. A refused command pulses done in the cycle after acceptance.
- R12: A row gate opens only onto bit lines whose levels do not change at that edge. A gate is never open while any rail is split, and at most one row gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Step strobe |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 00 write, 01 un-write, 10 read, 11 un-read |
| cmd_row | input | ROW_W | Row address |
| cmd_data | input | COLS | Data to write or to present for un-write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command refused, with done |
| rd_data | output | COLS | Column latch contents |
| tg_en | output | ROWS | Row transmission gate enables |
| rail_split | output | ROWS | Row inverter rail split |
| col_strobe | output | 1 | Column latch step active |
| bl_lvl | output | 2*COLS | Per-column bit-line level |

## Verification
The write and read paths are exercised with the patterns A5, 3C, 00 and FF on different rows. A5 and 3C show whether the polarity of each bit is correct. All-zero data tells a low-driven cell apart from a mid (cleared) one. All-ones data shows whether the read inversion is applied on every column. Round trips of write, read, un-read and un-write show whether each inverse leaves the row and the latch in a state where a fresh command is accepted. Deliberately wrong un-write data, a second read while a copy is held and an un-read of the wrong row show whether each guard refuses the command without disturbing the stored contents.

// File: rtl/rcell_pkg.sv
package rcell_pkg;
  localparam logic [1:0] LV_LOW  = 2'b00;
  localparam logic [1:0] LV_MID  = 2'b01;
  localparam logic [1:0] LV_HIGH = 2'b10;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'b00,
    OP_UNWRITE = 2'b01,
    OP_READ    = 2'b10,
    OP_UNREAD  = 2'b11
  } op_e;

  function automatic logic [1:0] lv_of(input logic b);
    return b ? LV_HIGH : LV_LOW;
  endfunction

  function automatic logic [1:0] lv_inv(input logic [1:0] l);
    case (l)
      LV_LOW:  return LV_HIGH;
      LV_HIGH: return LV_LOW;
      default: return LV_MID;
    endcase
  endfunction
endpackage

// File: rtl/rcell_cell_array.sv
module rcell_cell_array
  import rcell_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROWS-1:0]      tg_en,
  input  logic [2*COLS-1:0]    bl_in,
  input  logic [ROW_W-1:0]     rd_row,
  output logic [2*COLS-1:0]    row_nodes
);
  logic [1:0] node [ROWS][COLS];

  // Behavioural cell: the node follows its bit line while the row gate is open.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk) begin
        if (!rst_n)        node[r][c] <= LV_MID;
        else if (tg_en[r]) node[r][c] <= bl_in[2*c +: 2];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < COLS; c++) row_nodes[2*c +: 2] = node[rd_row][c];
  end
endmodule

// File: rtl/rcell_col_latch.sv
module rcell_col_latch
  import rcell_pkg::*;
#(
  parameter int COLS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              rel,
  input  logic [2*COLS-1:0] bl_in,
  output logic [COLS-1:0]   rd_data
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [1:0] held;
    always_ff @(posedge clk) begin
      if (!rst_n)   held <= LV_MID;
      else if (cap) held <= bl_in[2*c +: 2];
      else if (rel) held <= LV_MID;
    end
    // Line carries the inverted cell level: low on the line means a stored 1.
    assign rd_data[c] = (held == LV_LOW);
  end
endmodule

// File: rtl/rcell_seq_fsm.sv
module rcell_seq_fsm
  import rcell_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              quiet,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COLS-1:0]   cmd_data,
  input  logic [2*COLS-1:0] row_nodes,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ROW_W-1:0]  row_q,
  output logic [COLS-1:0]   data_q,
  output logic              gate_on,
  output logic              drv_en,
  output logic              split_en,
  output logic              cap_en,
  output logic              rel_en,
  output logic              col_strobe
);
  op_e        op_q;
  logic [1:0] step_q;
  logic       held_q;
  logic [ROW_W-1:0] held_row_q;
  logic       reject, accept, is_wr, last_step;
  logic [2*COLS-1:0] want_lv;

  always_comb begin
    for (int c = 0; c < COLS; c++) want_lv[2*c +: 2] = lv_of(cmd_data[c]);
  end

  always_comb begin
    reject = 1'b0;
    case (op_e'(cmd_op))
      OP_WRITE: begin
        for (int c = 0; c < COLS; c++)
          if (row_nodes[2*c +: 2] != LV_MID) reject = 1'b1;
      end
      OP_UNWRITE: reject = (row_nodes != want_lv);
      OP_READ:    reject = held_q;
      default:    reject = !held_q || (cmd_row != held_row_q);
    endcase
  end

  assign cmd_ready = !busy && quiet;
  assign accept    = cmd_valid && cmd_ready;
  assign is_wr     = (op_q == OP_WRITE) || (op_q == OP_UNWRITE);
  assign last_step = is_wr ? (step_q == 2'd3) : (step_q == 2'd2);

  // Write: open(1) drive(2) close(3) mid. Un-write: drive(1) open(2) mid(3) close.
  assign gate_on  = busy && (((op_q == OP_WRITE)   && (step_q == 2'd1 || step_q == 2'd2)) ||
                             ((op_q == OP_UNWRITE) && (step_q == 2'd2 || step_q == 2'd3)));
  assign drv_en   = busy && (((op_q == OP_WRITE)   && (step_q == 2'd2 || step_q == 2'd3)) ||
                             ((op_q == OP_UNWRITE) && (step_q == 2'd1 || step_q == 2'd2)));
  assign split_en   = busy && !is_wr && (step_q != 2'd0);
  assign col_strobe = busy && !is_wr && (step_q == 2'd2);
  assign cap_en     = busy && tick && (op_q == OP_READ)   && (step_q == 2'd1);
  assign rel_en     = busy && tick && (op_q == OP_UNREAD) && (step_q == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      op_q       <= OP_WRITE;
      step_q     <= '0;
      row_q      <= '0;
      data_q     <= '0;
      held_q     <= 1'b0;
      held_row_q <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (accept) begin
          if (reject) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            busy   <= 1'b1;
            op_q   <= op_e'(cmd_op);
            row_q  <= cmd_row;
            data_q <= cmd_data;
            step_q <= '0;
          end
        end
      end else if (tick) begin
        if (cap_en) begin
          held_q     <= 1'b1;
          held_row_q <= row_q;
        end
        if (rel_en) held_q <= 1'b0;
        if (last_step) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rcell_access_seq.sv
module rcell_access_seq
  import rcell_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COLS-1:0]   cmd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [COLS-1:0]   rd_data,
  output logic [ROWS-1:0]   tg_en,
  output logic [ROWS-1:0]   rail_split,
  output logic              col_strobe,
  output logic [2*COLS-1:0] bl_lvl
);
  logic [ROW_W-1:0]  row_q;
  logic [COLS-1:0]   data_q;
  logic [2*COLS-1:0] row_nodes;
  logic              gate_on, drv_en, split_en, cap_en, rel_en, quiet, lines_mid;
  logic [ROW_W-1:0]  rd_row;

  assign rd_row = busy ? row_q : cmd_row;

  for (genvar c = 0; c < COLS; c++) begin : g_bl
    assign bl_lvl[2*c +: 2] = split_en ? lv_inv(row_nodes[2*c +: 2]) :
                              drv_en   ? lv_of(data_q[c]) : LV_MID;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rowsel
    assign tg_en[r]      = gate_on  && (row_q == ROW_W'(r));
    assign rail_split[r] = split_en && (row_q == ROW_W'(r));
  end

  always_comb begin
    lines_mid = 1'b1;
    for (int c = 0; c < COLS; c++)
      if (bl_lvl[2*c +: 2] != LV_MID) lines_mid = 1'b0;
  end
  assign quiet = lines_mid && (tg_en == '0) && (rail_split == '0);

  rcell_seq_fsm #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) fsm_i (
    .clk, .rst_n, .tick, .quiet, .cmd_valid, .cmd_op, .cmd_row, .cmd_data,
    .row_nodes, .cmd_ready, .busy, .done, .err, .row_q, .data_q,
    .gate_on, .drv_en, .split_en, .cap_en, .rel_en, .col_strobe
  );

  rcell_cell_array #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) array_i (
    .clk, .rst_n, .tg_en, .bl_in(bl_lvl), .rd_row, .row_nodes
  );

  rcell_col_latch #(.COLS(COLS)) latch_i (
    .clk, .rst_n, .cap(cap_en), .rel(rel_en), .bl_in(bl_lvl), .rd_data
  );
endmodule

// File: rtl/rcell_access_chk.sv
module rcell_access_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              cmd_ready,
  input logic [ROWS-1:0]   tg_en,
  input logic [ROWS-1:0]   rail_split,
  input logic [2*COLS-1:0] bl_lvl
);
  localparam logic [2*COLS-1:0] ALL_MID = {COLS{2'b01}};

  p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!busy && tg_en == '0 && rail_split == '0 && bl_lvl == ALL_MID));

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(tg_en) && $stable(rail_split) && $stable(bl_lvl)));

  p_gate_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tg_en != '0) |-> busy);

  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ($past(busy) && !busy));

  p_gate_opens_matched_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tg_en != '0 && $past(tg_en) == '0) |-> (bl_lvl == $past(bl_lvl)));

  p_no_split_with_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !((tg_en != '0) && (rail_split != '0)));

  p_one_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tg_en));
endmodule

bind rcell_access_seq rcell_access_chk #(.ROWS(ROWS), .COLS(COLS)) chk_i (
  .clk, .rst_n, .tick, .busy, .done, .err, .cmd_ready, .tg_en, .rail_split, .bl_lvl
);

// File: tb/rcell_access_seq_tb_top.sv
`timescale 1ns/1ps
module rcell_access_seq_tb_top;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam logic [15:0] MIDS = 16'h5555;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_row = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_ready, busy, done, err, col_strobe;
  logic [7:0] rd_data;
  logic [3:0] tg_en, rail_split;
  logic [15:0] bl_lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rcell_access_seq #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk, .rst_n, .tick, .cmd_valid, .cmd_ready, .cmd_op, .cmd_row, .cmd_data,
    .busy, .done, .err, .rd_data, .tg_en, .rail_split, .col_strobe, .bl_lvl
  );

  function automatic logic [15:0] lvls(input logic [7:0] d);
    logic [15:0] v;
    for (int i = 0; i < 8; i++) v[2*i +: 2] = d[i] ? 2'b10 : 2'b00;
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] row, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_row = row; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic tk;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "tg_en", tg_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done/err", {done, err}, 0);
    chk("R1", "bl mid", bl_lvl, MIDS);
    chk("R1", "split", rail_split, 0);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "ready", cmd_ready, 1);
  endtask

  task automatic t_write(input logic [1:0] row, input logic [7:0] d);
    chk("R2", "ready before write", cmd_ready, 1);
    issue(2'b00, row, d);
    chk("R2", "busy after accept", {busy, cmd_ready}, 2'b10);
    repeat (3) @(negedge clk);
    chk("R3", "no tick hold gate", tg_en, 0);
    chk("R3", "no tick hold bl", bl_lvl, MIDS);
    tk;
    chk("R4", "w1 gate open", tg_en, 4'b1 << row);
    chk("R4", "w1 bl mid", bl_lvl, MIDS);
    tk;
    chk("R4", "w2 bl driven", bl_lvl, lvls(d));
    chk("R4", "w2 gate open", tg_en, 4'b1 << row);
    tk;
    chk("R4", "w3 gate closed", tg_en, 0);
    chk("R4", "w3 bl driven", bl_lvl, lvls(d));
    tk;
    chk("R4", "w4 done", {done, err, busy}, 3'b100);
    chk("R4", "w4 bl mid", bl_lvl, MIDS);
    @(negedge clk);
    chk("R11", "done one cycle", done, 0);
  endtask

  task automatic t_read(input logic [1:0] row, input logic [7:0] d);
    issue(2'b10, row, d);
    chk("R6", "r0 busy", busy, 1);
    tk;
    chk("R6", "r1 split", rail_split, 4'b1 << row);
    chk("R6", "r1 bl inverted", bl_lvl, lvls(~d));
    tk;
    chk("R6", "r2 rd_data", rd_data, d);
    chk("R6", "r2 strobe", col_strobe, 1);
    tk;
    chk("R6", "r3 done", {done, err, busy}, 3'b100);
    chk("R6", "r3 merged", {rail_split, bl_lvl}, {4'b0, MIDS});
    @(negedge clk);
    chk("R11", "read done pulse", done, 0);
  endtask

  task automatic t_unread(input logic [1:0] row, input logic [7:0] d);
    issue(2'b11, row, 8'h00);
    tk;
    chk("R10", "u1 split matches copy", bl_lvl, lvls(~d));
    chk("R10", "u1 copy still held", rd_data, d);
    tk;
    chk("R10", "u2 copy cleared", rd_data, 0);
    tk;
    chk("R10", "u3 done", {done, err, busy}, 3'b100);
    chk("R10", "u3 merged", {rail_split, bl_lvl}, {4'b0, MIDS});
  endtask

  task automatic t_unwrite(input logic [1:0] row, input logic [7:0] d);
    issue(2'b01, row, d);
    chk("R8", "uw accepted", {busy, err}, 2'b10);
    tk;
    chk("R8", "uw1 presented, gate shut", {tg_en, bl_lvl}, {4'b0, lvls(d)});
    tk;
    chk("R8", "uw2 gate open onto data", {tg_en, bl_lvl}, {4'b1 << row, lvls(d)});
    tk;
    chk("R8", "uw3 lines mid, gate open", {tg_en, bl_lvl}, {4'b1 << row, MIDS});
    tk;
    chk("R8", "uw4 done, gate shut", {done, err, tg_en}, {2'b10, 4'b0});
  endtask

  task automatic t_reject(input string req, input logic [1:0] op,
                          input logic [1:0] row, input logic [7:0] d);
    issue(op, row, d);
    chk(req, "refused with err", {done, err, busy}, 3'b110);
    chk(req, "lines untouched", {tg_en, rail_split, bl_lvl}, {8'b0, MIDS});
    @(negedge clk);
    chk(req, "err one cycle", {done, err}, 2'b00);
  endtask

  initial begin
    t_reset;
    t_write(2'd1, 8'hA5);
    t_read(2'd1, 8'hA5);
    t_reject("R7", 2'b10, 2'd2, 8'h00);
    t_reject("R10", 2'b11, 2'd2, 8'h00);
    t_unread(2'd1, 8'hA5);
    t_write(2'd0, 8'h00);
    t_read(2'd0, 8'h00);
    t_unread(2'd0, 8'h00);
    t_reject("R5", 2'b00, 2'd1, 8'h3C);
    t_reject("R9", 2'b01, 2'd1, 8'h5A);
    t_read(2'd1, 8'hA5);           // R9: contents kept after refusal
    t_unread(2'd1, 8'hA5);
    t_reject("R10", 2'b11, 2'd1, 8'h00);
    t_unwrite(2'd1, 8'hA5);
    t_reject("R9", 2'b01, 2'd1, 8'hA5); // R8: row now mid, old data no longer matches
    t_write(2'd1, 8'h3C);          // R8: cleared row accepts a new write
    t_read(2'd1, 8'h3C);
    t_unread(2'd1, 8'h3C);
    t_write(2'd3, 8'hFF);
    t_read(2'd3, 8'hFF);
    t_unread(2'd3, 8'hFF);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule